// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns one asynchronous, active-low power-on request pin into a staged set of chip reset signals. After the pin has been held long enough to count as a real reset and then released, the block holds an internal core reset for a fixed time. It then waits on a counted stand-in for PLL lock, clocked from the input clock divided by one or two. After lock it releases a hard reset and, three cycles later, a soft reset. All delays are counted on the single input clock `clk`.

Configuration straps are sampled in the same cycle the release is accepted. During the core-reset hold, a host may load a 32-bit reset configuration word; writes at any other time are dropped and flagged. Pulling the pin low in mid-sequence aborts the sequence. A pin pulse that is too short never starts a sequence and never disturbs a chip that is already running.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `porInN` is held low, `seqState` reads 1 (pin held), `intPorN`, `pllLock`, `hardRstN`, `softRstN` and `done` are all 0. State codes: 0 idle, 1 pin held, 2 core hold, 3 lock wait, 4 hard-reset wait, 5 run.
- R2: A low pulse on `porInN` spanning fewer than 16 rising edges returns the block to idle (state 0) if it began in idle. If it began in run (state 5), the state and all released outputs are unchanged. A pulse of exactly 16 edges starts a sequence.
- R3: `intPorN` goes high 1027 rising edges after the accepted release of `porInN`. This is 3 edges of synchronizer and decision latency plus a 1024-cycle hold in state 2.
- R4: `pllLock` goes high 6400 cycles after `intPorN` when `refDiv2`=0, and 12800 cycles after when `refDiv2`=1. `refDiv2` is sampled together with the straps.
- R5: `hardRstN` goes high 512 cycles after `pllLock`.
- R6: `softRstN` and `done` go high 515 cycles after `pllLock`, and the state becomes 5.
- R7: `strapLat` takes `strapIn` in the cycle the release is accepted and holds it otherwise. Bit layout: [0] config select, [1] config source, [2] sync mode, [3] 64-bit mode, [7:4] chip ID, [10:8] boot mode, [11] watchdog enable, [13:12] clock mode.
- R8: A write (`cfgWrEn`=1) in state 2 loads `cfgWrData` into `cfgWord` at the next edge. The last write in the window wins.
- R9: A write in any other state leaves `cfgWord` unchanged and sets `cfgErr`. `cfgErr` stays set from then on.
- R10: `porInN` going low in state 2, 3 or 4 forces state 1 and all reset outputs low within 3 edges. If that low pulse is shorter than 16 edges, the block then rests in idle.
- R11: The outputs are released in order: `intPorN`, `pllLock`, `hardRstN`, `softRstN`. None rises before the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all delays counted on it |
| porInN | input | 1 | Asynchronous power-on request, active low |
| refDiv2 | input | 1 | Lock-timer reference divide: 0 = by 1, 1 = by 2 |
| strapIn | input | 14 | Configuration strap pins |
| cfgWrEn | input | 1 | Host write strobe for the configuration word |
| cfgWrData | input | 32 | Host write data |
| intPorN | output | 1 | Internal core reset, active low |
| pllLock | output | 1 | Counted lock indication |
| hardRstN | output | 1 | Hard reset, active low |
| softRstN | output | 1 | Soft reset, active low |
| seqState | output | 3 | Sequencer state code |
| done | output | 1 | High once both hard and soft reset are released |
| strapLat | output | 14 | Straps captured at release |
| cfgWord | output | 32 | Reset configuration word |
| cfgErr | output | 1 | Sticky flag for writes outside the window |

## Verification
A wrong state or a miscounted shared counter shows up at the ports as a release edge off by some cycles. The scoreboard sees it on the very cycle the edge appears, or fails to appear, measured from the pin release. A glitch filter that counts wrongly shows up within about 20 cycles, either as a running chip whose resets drop or as an idle block that starts a sequence. A window decode error shows up one edge after the offending write, on `cfgWord` or `cfgErr`.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int STRAP_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PIN_HELD  = 3'd1,
    ST_CORE_HOLD = 3'd2,
    ST_LOCK_WAIT = 3'd3,
    ST_HARD_WAIT = 3'd4,
    ST_RUN       = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic armClr;
    logic capStraps;
    logic cfgWin;
  } seqCtl_t;

endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int MIN_PULSE = 16,
  parameter int CNT_W     = 13,
  parameter int CFG_W     = 32
) (
  input  logic               clk,
  input  logic               porInN,
  input  seqCtl_t            ctl,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               refDiv2,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               porSyncN,
  output logic               armed,
  output logic [CNT_W-1:0]   cnt,
  output logic               tick,
  output logic [STRAP_W-1:0] strapLat,
  output logic [CFG_W-1:0]   cfgWord,
  output logic               cfgErr
);

  localparam int LOW_W = $clog2(MIN_PULSE + 1);

  // power-up values: the block has no reset other than the pin it filters
  logic               syncA     = 1'b0;
  logic               syncB     = 1'b0;
  logic [LOW_W-1:0]   lowCnt    = '0;
  logic               armedQ    = 1'b0;
  logic [CNT_W-1:0]   cntQ      = '0;
  logic               divTog    = 1'b0;
  logic               div2Lat   = 1'b0;
  logic [STRAP_W-1:0] strapQ    = '0;
  logic [CFG_W-1:0]   cfgQ      = '0;
  logic               errQ      = 1'b0;

  always_ff @(posedge clk) begin
    syncA <= porInN;
    syncB <= syncA;
  end
  assign porSyncN = syncB;

  // consecutive-low counter, saturating at the minimum valid width
  always_ff @(posedge clk) begin
    if (porSyncN)                                lowCnt <= '0;
    else if (lowCnt != LOW_W'(MIN_PULSE))        lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.armClr)                                        armedQ <= 1'b0;
    else if (!porSyncN && lowCnt == LOW_W'(MIN_PULSE - 1)) armedQ <= 1'b1;
  end
  assign armed = armedQ;

  // shared phase counter with divided-reference tick
  always_ff @(posedge clk) begin
    if (ctl.cntClr) begin
      cntQ   <= '0;
      divTog <= 1'b0;
    end else begin
      divTog <= ~divTog;
      if (ctl.cntInc) cntQ <= cntQ + 1'b1;
    end
  end
  assign cnt  = cntQ;
  assign tick = !div2Lat || divTog;

  always_ff @(posedge clk) begin
    if (ctl.capStraps) begin
      strapQ  <= strapIn;
      div2Lat <= refDiv2;
    end
  end
  assign strapLat = strapQ;

  always_ff @(posedge clk) begin
    if (cfgWrEn && ctl.cfgWin)  cfgQ <= cfgWrData;
    if (cfgWrEn && !ctl.cfgWin) errQ <= 1'b1;
  end
  assign cfgWord = cfgQ;
  assign cfgErr  = errQ;

  p_lowcnt_sat_r2: assert property (@(posedge clk) disable iff (!porSyncN)
    lowCnt <= LOW_W'(MIN_PULSE));

  p_cfg_window_r8: assert property (@(posedge clk) disable iff (!porSyncN)
    !ctl.cfgWin |=> $stable(cfgWord));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!porSyncN)
    cfgErr |=> cfgErr);

  p_straps_hold_r7: assert property (@(posedge clk) disable iff (!porSyncN)
    !ctl.capStraps |=> $stable(strapLat));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int INT_HOLD = 1024,
  parameter int LOCK_CYC = 6400,
  parameter int HRST_DLY = 512,
  parameter int SRST_DLY = 515,
  parameter int CNT_W    = 13
) (
  input  logic             clk,
  input  logic             porSyncN,
  input  logic             armed,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  output seqCtl_t          ctl,
  output logic [2:0]       stateOut,
  output logic             intPorN,
  output logic             pllLock,
  output logic             hardRstN,
  output logic             softRstN,
  output logic             done
);

  seqState_e state = ST_IDLE;
  seqState_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (!porSyncN) nxt = ST_PIN_HELD;
      ST_PIN_HELD:  if (porSyncN) nxt = armed ? ST_CORE_HOLD : ST_IDLE;
      ST_CORE_HOLD: if (!porSyncN) nxt = ST_PIN_HELD;
                    else if (cnt == CNT_W'(INT_HOLD - 1)) nxt = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (!porSyncN) nxt = ST_PIN_HELD;
                    else if (tick && cnt == CNT_W'(LOCK_CYC - 1)) nxt = ST_HARD_WAIT;
      ST_HARD_WAIT: if (!porSyncN) nxt = ST_PIN_HELD;
                    else if (cnt == CNT_W'(SRST_DLY - 1)) nxt = ST_RUN;
      ST_RUN:       if (armed) nxt = ST_PIN_HELD;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) state <= nxt;

  always_comb begin
    ctl.cntClr    = (nxt != state);
    ctl.cntInc    = (state == ST_CORE_HOLD) || (state == ST_HARD_WAIT) ||
                    (state == ST_LOCK_WAIT && tick);
    ctl.armClr    = (state == ST_PIN_HELD) && porSyncN;
    ctl.capStraps = (state == ST_PIN_HELD) && porSyncN && armed;
    ctl.cfgWin    = (state == ST_CORE_HOLD);
  end

  assign stateOut = state;
  assign intPorN  = (state == ST_LOCK_WAIT) || (state == ST_HARD_WAIT) || (state == ST_RUN);
  assign pllLock  = (state == ST_HARD_WAIT) || (state == ST_RUN);
  assign hardRstN = (state == ST_RUN) ||
                    (state == ST_HARD_WAIT && cnt >= CNT_W'(HRST_DLY));
  assign softRstN = (state == ST_RUN);
  assign done     = softRstN && hardRstN;

  p_core_hold_len_r3: assert property (@(posedge clk) disable iff (!porSyncN)
    $rose(intPorN) |-> $past(cnt) == CNT_W'(INT_HOLD - 1));

  p_hard_delay_r5: assert property (@(posedge clk) disable iff (!porSyncN)
    $rose(hardRstN) |-> pllLock && cnt == CNT_W'(HRST_DLY));

  p_soft_after_hard_r6: assert property (@(posedge clk) disable iff (!porSyncN)
    $rose(softRstN) |-> $past(hardRstN) && $past(cnt) == CNT_W'(SRST_DLY - 1));

  p_lock_order_r11: assert property (@(posedge clk) disable iff (!porSyncN)
    $rose(pllLock) |-> $past(intPorN));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MIN_PULSE = 16,
  parameter int INT_HOLD  = 1024,
  parameter int LOCK_CYC  = 6400,
  parameter int HRST_DLY  = 512,
  parameter int SRST_DLY  = 515,
  parameter int CFG_W     = 32
) (
  input  logic               clk,
  input  logic               porInN,
  input  logic               refDiv2,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               intPorN,
  output logic               pllLock,
  output logic               hardRstN,
  output logic               softRstN,
  output logic [2:0]         seqState,
  output logic               done,
  output logic [STRAP_W-1:0] strapLat,
  output logic [CFG_W-1:0]   cfgWord,
  output logic               cfgErr
);

  localparam int MAX_A = (INT_HOLD > LOCK_CYC) ? INT_HOLD : LOCK_CYC;
  localparam int MAX_C = (MAX_A > SRST_DLY) ? MAX_A : SRST_DLY;
  localparam int CNT_W = $clog2(MAX_C + 1);

  seqCtl_t          ctl;
  logic             porSyncN;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  rst_seq_dp #(
    .MIN_PULSE(MIN_PULSE), .CNT_W(CNT_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .porInN(porInN), .ctl(ctl), .strapIn(strapIn),
    .refDiv2(refDiv2), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .porSyncN(porSyncN), .armed(armed), .cnt(cnt), .tick(tick),
    .strapLat(strapLat), .cfgWord(cfgWord), .cfgErr(cfgErr)
  );

  rst_seq_fsm #(
    .INT_HOLD(INT_HOLD), .LOCK_CYC(LOCK_CYC), .HRST_DLY(HRST_DLY),
    .SRST_DLY(SRST_DLY), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .porSyncN(porSyncN), .armed(armed), .cnt(cnt), .tick(tick),
    .ctl(ctl), .stateOut(seqState), .intPorN(intPorN), .pllLock(pllLock),
    .hardRstN(hardRstN), .softRstN(softRstN), .done(done)
  );

endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        porInN = 1'b0;
  logic        refDiv2 = 1'b0;
  logic [13:0] strapIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        intPorN, pllLock, hardRstN, softRstN, done, cfgErr;
  logic [2:0]  seqState;
  logic [13:0] strapLat;
  logic [31:0] cfgWord;

  rst_seq_ctrl u_rst_seq_ctrl (
    .clk(clk), .porInN(porInN), .refDiv2(refDiv2), .strapIn(strapIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .intPorN(intPorN),
    .pllLock(pllLock), .hardRstN(hardRstN), .softRstN(softRstN),
    .seqState(seqState), .done(done), .strapLat(strapLat),
    .cfgWord(cfgWord), .cfgErr(cfgErr)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int id; int at; } evt_t;
  evt_t expQ[$];
  int nChecks = 0;
  int nFail = 0;
  string reqOf[4] = '{"R3", "R4", "R5", "R6"};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every release edge must match the head of the expectation queue
  logic [3:0] prevO = '0;
  logic [3:0] nowO;
  always @(negedge clk) begin
    nowO = {softRstN, hardRstN, pllLock, intPorN};
    for (int i = 0; i < 4; i++) begin
      if (nowO[i] && !prevO[i]) begin
        if (expQ.size() == 0) begin
          nChecks++; nFail++;
          $display("FAIL %s/R11 actual=rise of output %0d at cycle %0d expected=none", reqOf[i], i, cyc);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          chk({reqOf[e.id], "/R11 order"}, i, e.id);
          chk({reqOf[e.id], " timing"}, cyc, e.at);
        end
      end
    end
    prevO = nowO;
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic releasePin(logic d2, logic [13:0] s);
    int t0, lk;
    refDiv2 = d2;
    strapIn = s;
    @(negedge clk);
    porInN = 1'b1;
    t0 = cyc;
    lk = t0 + 1027 + (d2 ? 12800 : 6400);
    expQ.push_back('{0, t0 + 1027});
    expQ.push_back('{1, lk});
    expQ.push_back('{2, lk + 512});
    expQ.push_back('{3, lk + 515});
  endtask

  task automatic hostWrite(logic [31:0] d);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitDone();
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    waitCyc(30);
    // R1: held pin
    chk("R1 state", seqState, 3'd1);
    chk("R1 outputs", {intPorN, pllLock, hardRstN, softRstN, done}, 5'b0);

    // first sequence, divide by 1
    releasePin(1'b0, 14'h2A5C);
    waitCyc(10);
    chk("R3 core hold state", seqState, 3'd2);
    hostWrite(32'hA5A5_0001);
    waitCyc(5);
    hostWrite(32'h1234_5678);
    chk("R8 last write wins", cfgWord, 32'h1234_5678);
    chk("R9 no error in window", cfgErr, 1'b0);
    waitDone();
    waitCyc(2);
    chk("R6 done", {done, seqState}, {1'b1, 3'd5});
    chk("R7 straps", strapLat, 14'h2A5C);

    // R9: write outside window
    hostWrite(32'hDEAD_BEEF);
    chk("R9 word unchanged", cfgWord, 32'h1234_5678);
    chk("R9 error set", cfgErr, 1'b1);

    // R2: short glitch in run
    porInN = 1'b0;
    waitCyc(15);
    porInN = 1'b1;
    waitCyc(25);
    chk("R2 run glitch state", seqState, 3'd5);
    chk("R2 run glitch outputs", {intPorN, pllLock, hardRstN, softRstN}, 4'hF);

    // R10: long pulse from run
    porInN = 1'b0;
    waitCyc(40);
    chk("R10 long pulse state", seqState, 3'd1);
    chk("R10 long pulse outputs", {intPorN, pllLock, hardRstN, softRstN}, 4'h0);

    // divide by 2, abort in lock wait
    releasePin(1'b1, 14'h1337);
    waitCyc(2000);
    chk("R4 lock wait", {seqState, intPorN, pllLock}, {3'd3, 1'b1, 1'b0});
    expQ.delete();
    porInN = 1'b0;
    waitCyc(5);
    chk("R10 abort outputs", {intPorN, pllLock, hardRstN, softRstN}, 4'h0);
    waitCyc(3);
    porInN = 1'b1;
    waitCyc(10);
    chk("R10 short abort idle", seqState, 3'd0);

    // R2: 15-edge pulse from idle is ignored
    porInN = 1'b0;
    waitCyc(15);
    porInN = 1'b1;
    waitCyc(10);
    chk("R2 short pulse idle", {seqState, intPorN}, {3'd0, 1'b0});

    // R2: exactly 16 edges starts a sequence
    porInN = 1'b0;
    waitCyc(15);
    releasePin(1'b1, 14'h0F0F);
    waitDone();
    waitCyc(2);
    chk("R6 done after 16-edge pulse", {done, seqState}, {1'b1, 3'd5});
    chk("R7 straps second capture", strapLat, 14'h0F0F);
    chk("R4 all events seen", expQ.size(), 0);

    summary();
  end

endmodule